// File: doc/BRIEF.md
# Buffered SPI Slave Port with Overrun Detection

This block is the slave end of an SPI link. An external master supplies the serial clock and an active-low select line. The block runs on its own system clock. It passes the serial clock, the master's data line and the select line through two-flop synchronisers, then finds the clock edges by comparing successive synchronised samples. Clock polarity, clock phase, bit order and a 7-bit or 8-bit character length are set by static configuration inputs.

Local logic writes the next outgoing character into a transmit buffer. That character moves into the shift register as soon as the register is free, so it is ready before the master starts clocking. When a character completes, the received bits go to a receive buffer and a status flag is raised. If a second character completes while the receive buffer still holds unread data, the new character overwrites the buffer and a sticky overrun flag is set. The MISO driver is modelled as a data output plus an output enable.

The system clock must run at least four times faster than the serial clock.

Top module: `spi_slave_buf`

## Requirements
- R1: `misoOe` is 1 only while the synchronised select is low, which lags `selN` by two to three system clocks. Whenever `misoOe` is 0, `misoOut` is 0.
- R2: A `txWrite` pulse stores `txData` and clears `txEmpty`. When the shift register is free (no character held and no bits counted), the buffer moves into it within two cycles and `txEmpty` returns to 1.
- R3: The leading edge is the rising SCK edge when `cfgCpol`=0 and the falling edge when `cfgCpol`=1. MOSI is sampled on the leading edge when `cfgCpha`=0 and on the trailing edge when `cfgCpha`=1. MISO changes on the other edge.
- R4: With `cfgCpha`=0, the first outgoing bit is on `misoOut` once select has been low for three cycles, before any SCK edge.
- R5: `cfgLsbFirst`=1 sends and receives bit 0 first; 0 sends the top bit of the character first. `cfgShort`=1 makes a character 7 bits (bits 6..0), and `rxData[7]` then reads 0.
- R6: When the last bit of a character is sampled, the character is copied to `rxData` and `rxFull` is set. `rxRead` clears `rxFull`.
- R7: If a character completes while `rxFull` is 1 and no `rxRead` is given in that cycle, `overrun` is set and `rxData` takes the new character. `overrun` stays set until `rxRead` or `ovrClear`. `ovrClear` leaves `rxFull` unchanged.
- R8: If select rises before a character is complete, the bit count is reset and `rxFull` is not set. A transmit character already moved into the shift register is kept and is sent in full at the next selection.
- R9: A character clocked out when no transmit data was loaded is all zeros on MISO.
- R10: After reset, `txEmpty`=1, `rxFull`=0, `overrun`=0, `misoOe`=0 and `rxData`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgCpol | input | 1 | Idle level of SCK |
| cfgCpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfgLsbFirst | input | 1 | 1: least significant bit first |
| cfgShort | input | 1 | 1: 7-bit characters |
| txData | input | 8 | Character to transmit |
| txWrite | input | 1 | Write strobe for the transmit buffer |
| rxRead | input | 1 | Status read; clears receive-full and overrun |
| ovrClear | input | 1 | Clears the overrun flag only |
| rxData | output | 8 | Receive buffer |
| txEmpty | output | 1 | Transmit buffer free |
| rxFull | output | 1 | Receive buffer holds an unread character |
| overrun | output | 1 | Sticky receive overrun flag |
| sckIn | input | 1 | Serial clock from the master |
| mosiIn | input | 1 | Serial data from the master |
| selN | input | 1 | Active-low slave select |
| misoOut | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for the MISO driver |

## Verification
The assertions assume two things about the inputs. First, every SCK level and every select level is held for several system clocks, so the synchronisers never lose an edge. Second, configuration changes only while select is high. The bench model of the master keeps each half period of SCK at six system clocks. It parks SCK at its idle level and waits before lowering select. It changes mode settings only between transfers, and drives MOSI well ahead of each sampling edge. Random runs draw the mode, the data and whether the buffers are written or read. An aborted character is the one directed case that breaks the normal framing.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  typedef struct packed {
    logic sample;  // sampling edge while selected
    logic done;    // sampling edge of the last bit of a character
    logic idle;    // select inactive (synchronised)
  } ctrlStrobe_t;
endpackage

// File: rtl/spi_slave_ctrl.sv
module spi_slave_ctrl
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic             cfgShort,
  input  logic             sckIn,
  input  logic             mosiIn,
  input  logic             selN,
  output ctrlStrobe_t      strobe,
  output logic             mosiBit,
  output logic [CNT_W-1:0] bitCnt,
  output logic [CNT_W-1:0] outPos
);
  logic [SYNC_STAGES-1:0] sckSync, mosiSync, selSync;
  logic sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      selSync  <= '1;
      sckPrev  <= 1'b0;
    end else begin
      sckSync  <= {sckSync[SYNC_STAGES-2:0], sckIn};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      selSync  <= {selSync[SYNC_STAGES-2:0], selN};
      sckPrev  <= sckSync[SYNC_STAGES-1];
    end
  end

  logic sckNow, sckRise, sckFall, leadEdge, trailEdge;
  logic selActive, sampleEdge, shiftEdge, lastBit;
  logic [CNT_W-1:0] charLen;

  always_comb begin
    sckNow     = sckSync[SYNC_STAGES-1];
    sckRise    = sckNow & ~sckPrev;
    sckFall    = ~sckNow & sckPrev;
    leadEdge   = cfgCpol ? sckFall : sckRise;
    trailEdge  = cfgCpol ? sckRise : sckFall;
    selActive  = ~selSync[SYNC_STAGES-1];
    sampleEdge = selActive & (cfgCpha ? trailEdge : leadEdge);
    shiftEdge  = selActive & (cfgCpha ? leadEdge : trailEdge);
    charLen    = cfgShort ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
    lastBit    = (bitCnt == charLen - CNT_W'(1));
  end

  // bitCnt counts sampled bits; outPos selects the bit on MISO and moves on shift edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      outPos <= '0;
    end else if (!selActive) begin
      bitCnt <= '0;
      outPos <= '0;
    end else begin
      if (sampleEdge) bitCnt <= lastBit ? '0 : bitCnt + CNT_W'(1);
      if (shiftEdge)  outPos <= bitCnt;
    end
  end

  assign strobe.sample = sampleEdge;
  assign strobe.done   = sampleEdge & lastBit;
  assign strobe.idle   = ~selActive;
  assign mosiBit       = mosiSync[SYNC_STAGES-1];
endmodule

// File: rtl/spi_slave_dp.sv
module spi_slave_dp
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              mosiBit,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [CNT_W-1:0]  outPos,
  input  logic              cfgLsbFirst,
  input  logic              cfgShort,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              ovrClear,
  output logic [DATA_W-1:0] rxData,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              overrun,
  output logic              misoOut,
  output logic              misoOe
);
  logic [DATA_W-1:0] txBuf, txShift, rxShift, rxNext;
  logic txHeld, loadShift;
  logic [CNT_W-1:0] charLen, inPos, sendPos;
  logic [IDX_W-1:0] inIdx, outIdx;

  always_comb begin
    charLen = cfgShort ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
    inPos   = cfgLsbFirst ? bitCnt : charLen - CNT_W'(1) - bitCnt;
    sendPos = cfgLsbFirst ? outPos : charLen - CNT_W'(1) - outPos;
    inIdx   = inPos[IDX_W-1:0];
    outIdx  = sendPos[IDX_W-1:0];
    rxNext  = rxShift;
    rxNext[inIdx] = mosiBit;
    if (cfgShort) rxNext[DATA_W-1] = 1'b0;
    loadShift = ~txHeld & ~txEmpty & (bitCnt == '0);
  end

  // transmit buffer and shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txEmpty <= 1'b1;
      txHeld  <= 1'b0;
      txShift <= '0;
    end else begin
      if (txWrite) begin
        txBuf   <= txData;
        txEmpty <= 1'b0;
      end else if (loadShift) begin
        txEmpty <= 1'b1;
      end
      if (loadShift) begin
        txShift <= txBuf;
        txHeld  <= 1'b1;
      end else if (strobe.done) begin
        txShift <= '0;
        txHeld  <= 1'b0;
      end
    end
  end

  // receive path and status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (strobe.sample) rxShift <= rxNext;
      if (strobe.done) begin
        rxData <= rxNext;
        rxFull <= 1'b1;
        if (rxFull && !rxRead) overrun <= 1'b1;
        else if (rxRead || ovrClear) overrun <= 1'b0;
      end else if (rxRead) begin
        rxFull  <= 1'b0;
        overrun <= 1'b0;
      end else if (ovrClear) begin
        overrun <= 1'b0;
      end
    end
  end

  assign misoOe  = ~strobe.idle;
  assign misoOut = misoOe & txShift[outIdx];
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgLsbFirst,
  input  logic              cfgShort,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              ovrClear,
  output logic [DATA_W-1:0] rxData,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              overrun,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              selN,
  output logic              misoOut,
  output logic              misoOe
);
  ctrlStrobe_t      strobe;
  logic             mosiBit;
  logic [CNT_W-1:0] bitCnt, outPos;

  spi_slave_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgShort(cfgShort), .sckIn(sckIn), .mosiIn(mosiIn), .selN(selN),
    .strobe(strobe), .mosiBit(mosiBit), .bitCnt(bitCnt), .outPos(outPos)
  );

  spi_slave_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mosiBit(mosiBit),
    .bitCnt(bitCnt), .outPos(outPos), .cfgLsbFirst(cfgLsbFirst),
    .cfgShort(cfgShort), .txData(txData), .txWrite(txWrite),
    .rxRead(rxRead), .ovrClear(ovrClear), .rxData(rxData),
    .txEmpty(txEmpty), .rxFull(rxFull), .overrun(overrun),
    .misoOut(misoOut), .misoOe(misoOe)
  );
endmodule

// File: rtl/spi_slave_buf_chk.sv
module spi_slave_buf_chk (
  input logic clk,
  input logic rstN,
  input logic selN,
  input logic misoOe,
  input logic misoOut,
  input logic txWrite,
  input logic txEmpty,
  input logic rxRead,
  input logic ovrClear,
  input logic rxFull,
  input logic overrun
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && misoOe) |-> !$past(selN, 2)); // R1
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !misoOe |-> !misoOut); // R1
  AST_TXEMPTY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> $past(txWrite)); // R2
  AST_RXFULL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(rxRead)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !rxRead && !ovrClear) |=> overrun); // R7
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(rxFull) && rxFull)); // R7
endmodule

bind spi_slave_buf spi_slave_buf_chk u_chk (
  .clk(clk), .rstN(rstN), .selN(selN), .misoOe(misoOe), .misoOut(misoOut),
  .txWrite(txWrite), .txEmpty(txEmpty), .rxRead(rxRead), .ovrClear(ovrClear),
  .rxFull(rxFull), .overrun(overrun)
);

// File: tb/spi_slave_buf_tb.sv
module spi_slave_buf_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgCpol = 1'b0, cfgCpha = 1'b0, cfgLsbFirst = 1'b0, cfgShort = 1'b0;
  logic [7:0] txData = '0;
  logic txWrite = 1'b0, rxRead = 1'b0, ovrClear = 1'b0;
  logic [7:0] rxData;
  logic txEmpty, rxFull, overrun;
  logic sckIn = 1'b0, mosiIn = 1'b0, selN = 1'b1;
  logic misoOut, misoOe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_slave_buf u_dut (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgLsbFirst(cfgLsbFirst), .cfgShort(cfgShort), .txData(txData),
    .txWrite(txWrite), .rxRead(rxRead), .ovrClear(ovrClear), .rxData(rxData),
    .txEmpty(txEmpty), .rxFull(rxFull), .overrun(overrun), .sckIn(sckIn),
    .mosiIn(mosiIn), .selN(selN), .misoOut(misoOut), .misoOe(misoOe)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] maskWord(input logic [7:0] w, input logic shortMode);
    return shortMode ? (w & 8'h7F) : w;
  endfunction

  task automatic writeTx(input logic [7:0] w);
    txData = w; txWrite = 1'b1;
    waitN(1);
    txWrite = 1'b0;
    waitN(3);
  endtask

  task automatic pulseRead();
    rxRead = 1'b1; waitN(1); rxRead = 1'b0; waitN(1);
  endtask

  // master model: leaves select low on return
  task automatic spiXfer(input logic [7:0] mosiWord, input int nBits, output logic [7:0] misoWord);
    int len;
    len = cfgShort ? 7 : 8;
    misoWord = '0;
    sckIn = cfgCpol;
    waitN(4);
    selN = 1'b0;
    waitN(8);
    for (int i = 0; i < nBits; i++) begin
      int pos;
      pos = cfgLsbFirst ? i : len - 1 - i;
      if (!cfgCpha) begin
        mosiIn = mosiWord[pos]; waitN(HALF);
        misoWord[pos] = misoOut;
        sckIn = ~cfgCpol; waitN(HALF);
        sckIn = cfgCpol;
      end else begin
        sckIn = ~cfgCpol; mosiIn = mosiWord[pos]; waitN(HALF);
        misoWord[pos] = misoOut;
        sckIn = cfgCpol; waitN(HALF);
      end
    end
    waitN(HALF);
  endtask

  task automatic deselect();
    selN = 1'b1; waitN(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, sw, mw;
    logic expFull, expOvr, doLoad;
    void'($urandom(32'h5EED));
    waitN(5);
    rstN = 1'b1;
    waitN(2);
    // R10 reset state
    chk("R10 txEmpty", txEmpty, 1); chk("R10 rxFull", rxFull, 0);
    chk("R10 overrun", overrun, 0); chk("R10 misoOe", misoOe, 0);
    chk("R10 rxData", rxData, 0);

    // R2 preload, R4 first bit before clock, R1 enable
    txData = 8'hA5; txWrite = 1'b1; waitN(1); txWrite = 1'b0;
    chk("R2 txEmpty cleared by write", txEmpty, 0);
    waitN(3);
    chk("R2 txEmpty set after move", txEmpty, 1);
    selN = 1'b0; waitN(4);
    chk("R1 misoOe while selected", misoOe, 1);
    chk("R4 first bit before clock", misoOut, 1);
    selN = 1'b1; waitN(5);
    chk("R1 misoOe after deselect", misoOe, 0);
    spiXfer(8'h3C, 8, got); deselect();
    chk("R3 mode0 miso word", got, 8'hA5);
    chk("R6 rxData", rxData, 8'h3C);
    chk("R6 rxFull set", rxFull, 1);
    pulseRead();
    chk("R6 rxFull cleared by read", rxFull, 0);

    // R3 R5: every mode combination
    for (int m = 0; m < 16; m++) begin
      cfgCpol = m[0]; cfgCpha = m[1]; cfgLsbFirst = m[2]; cfgShort = m[3];
      sw = 8'($urandom); mw = 8'($urandom);
      writeTx(sw);
      spiXfer(mw, cfgShort ? 7 : 8, got); deselect();
      chk("R3 R5 miso word", got, maskWord(sw, cfgShort));
      chk("R5 rx word", rxData, maskWord(mw, cfgShort));
      pulseRead();
    end
    cfgCpol = 0; cfgCpha = 0; cfgLsbFirst = 0; cfgShort = 0;

    // R7 overrun
    writeTx(8'h11); spiXfer(8'h21, 8, got); deselect();
    chk("R7 no overrun on first", overrun, 0);
    writeTx(8'h12); spiXfer(8'h42, 8, got); deselect();
    chk("R7 overrun set", overrun, 1);
    chk("R7 new character overwrites", rxData, 8'h42);
    waitN(20);
    chk("R7 overrun sticky", overrun, 1);
    ovrClear = 1'b1; waitN(1); ovrClear = 1'b0; waitN(1);
    chk("R7 ovrClear clears overrun", overrun, 0);
    chk("R7 ovrClear keeps rxFull", rxFull, 1);
    spiXfer(8'h63, 8, got); deselect();
    chk("R7 overrun again", overrun, 1);
    pulseRead();
    chk("R7 read clears overrun", overrun, 0);
    chk("R7 read clears rxFull", rxFull, 0);

    // R9 nothing loaded
    spiXfer(8'h77, 8, got); deselect();
    chk("R9 zeros without preload", got, 8'h00);
    pulseRead();

    // R8 abort mid character
    writeTx(8'h5A);
    spiXfer(8'hFF, 3, got); deselect();
    chk("R8 no rxFull after abort", rxFull, 0);
    chk("R8 txEmpty after move", txEmpty, 1);
    spiXfer(8'h81, 8, got); deselect();
    chk("R8 held word resent", got, 8'h5A);
    chk("R8 rx after abort", rxData, 8'h81);
    pulseRead();

    // random mix
    expFull = 0; expOvr = 0;
    for (int k = 0; k < 40; k++) begin
      cfgCpol = 1'($urandom); cfgCpha = 1'($urandom);
      cfgLsbFirst = 1'($urandom); cfgShort = 1'($urandom);
      sw = 8'($urandom); mw = 8'($urandom);
      doLoad = ($urandom % 4) != 0;
      if (doLoad) writeTx(sw);
      spiXfer(mw, cfgShort ? 7 : 8, got); deselect();
      expOvr = expOvr | expFull; expFull = 1;
      chk("R3 R9 random miso", got, doLoad ? maskWord(sw, cfgShort) : 8'h00);
      chk("R5 R6 random rx", rxData, maskWord(mw, cfgShort));
      chk("R6 random rxFull", rxFull, expFull);
      chk("R7 random overrun", overrun, expOvr);
      if (($urandom % 3) != 0) begin
        pulseRead();
        expFull = 0; expOvr = 0;
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule